// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block decides, every cycle, whether a small pipelined processor must leave its normal instruction stream, and where it goes. Six kinds of event compete for entry: a reset request, a non-maskable break, a maskable break, a hardware exception with one of five cause codes, the external interrupt line and a software user-exception request. Each request is captured into a pending flag. A fixed-priority arbiter then picks at most one eligible event per cycle. Eligibility depends on three status flags held inside the block: interrupt enable, break in progress and exception enable.

For the chosen event the block presents an entry record. The record holds the branch vector, the register-file index that receives the return address, the return PC (the decode-stage PC in the cycle the event is taken), the hardware cause code and a squash flag. The squash flag tells the pipeline whether the execute-stage instruction is killed or allowed to complete. In the same cycle the block updates the status flags the way the event demands. Software can rewrite the flags through a plain write port, for example to re-arm interrupts after a handler.

The entry record leaves on a valid/ready stream. Once `ent_valid` rises, the record stays unchanged until `ent_ready` is seen high. While the record is stalled, no new event is taken, and every request stays pending. An event can be taken in the same cycle that the previous record is accepted.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `ent_valid`, `st_ie`, `st_bip` and `st_ee` are 0. The first record after release is a reset entry: vector 0x00, register index 0, return PC 0, squash 1.
- R2: Each kind of event has a fixed vector and return register. User exception: 0x08 and index 15. Interrupt: 0x10 and index 14. Either break: 0x18 and index 16. Hardware exception: 0x20 and index 17. The return PC is `dec_pc` in the cycle the event is taken.
- R3: The priority order is: reset, non-maskable break, maskable break, hardware exception, interrupt, user exception. At most one event is taken per cycle, and the others stay pending. A request sampled at clock edge k can appear on `ent_valid` after edge k+1 at the earliest.
- R4: An interrupt is taken only when IE=1 and BIP=0. Taking it clears IE.
- R5: Taking either kind of break sets BIP. A maskable break is eligible only when BIP=0. A non-maskable break is always eligible.
- R6: A hardware exception is eligible only when EE=1 and BIP=0. Taking it clears EE. Input `hw_cause` bit i carries cause ID i+1: bit0 unaligned access (1), bit1 instruction bus error (2), bit2 illegal opcode (3), bit3 data bus error (4), bit4 divide by zero (5). When several causes are pending, the lowest ID is taken first and the rest stay pending. `ent_cause` is 0 for every other kind of event.
- R7: `ent_squash` is 1 for reset and hardware-exception entries. It is 0 for interrupt, break and user-exception entries.
- R8: While `ent_valid`=1 and `ent_ready`=0, the record is held unchanged and no event is taken. With `ent_valid`=0 or `ent_ready`=1, a pending eligible event is taken at that edge. If nothing is taken at such an edge, `ent_valid` drops to 0.
- R9: `msr_we`=1 loads the status flags from `msr_wdata`: bit0 is IE, bit1 is BIP, bit2 is EE. Eligibility in that cycle uses the old flags. If an event is taken in the same cycle, it overrides only the flags it changes.
- R10: With `IRQ_EDGE`=0 the interrupt request is the live level of `irq_line`. With `IRQ_EDGE`=1 the edge chosen by `EDGE_POS` is latched (rising edge when `EDGE_POS`=1, falling edge when 0). The latched request holds until the interrupt is taken. A line that already rests at the active level when reset is released does not count as an edge.
- R11: A reset entry clears IE, BIP and EE and discards all other pending requests. Requests that arrive in the same cycle are still captured. The block reset leaves a reset request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| rst_req | input | 1 | Reset event request pulse |
| nmbrk_req | input | 1 | Non-maskable break request pulse |
| brk_req | input | 1 | Maskable break request pulse |
| usr_req | input | 1 | User exception request pulse |
| hw_cause | input | NCAUSE | Hardware exception cause pulses, bit i is cause ID i+1 |
| irq_line | input | 1 | External interrupt line |
| dec_pc | input | AW | Decode-stage PC, saved as return address |
| msr_we | input | 1 | Status flag write strobe |
| msr_wdata | input | 3 | Status flag write data {EE, BIP, IE} |
| ent_ready | input | 1 | Pipeline accepts the entry record |
| ent_valid | output | 1 | Entry record valid |
| ent_vec | output | AW | Branch vector address |
| ent_rf_idx | output | 5 | Register index for the return address |
| ent_ret_pc | output | AW | Return PC |
| ent_cause | output | $clog2(NCAUSE+1) | Hardware exception cause ID, 0 otherwise |
| ent_squash | output | 1 | Execute-stage instruction is squashed |
| st_ie | output | 1 | Interrupt enable flag |
| st_bip | output | 1 | Break-in-progress flag |
| st_ee | output | 1 | Exception enable flag |

## Verification
The bench first applies directed patterns, each aimed at one question:
- Interrupt level held against IE=0, then against IE=1, which separates masking from taking.
- A maskable break repeated while BIP is set, which separates it from a non-maskable break.
- Two hardware causes pending together, which shows the lowest-ID order and that the second cause waits for EE.
- Several event kinds raised in one cycle, which exposes the priority chain and the retention of the losers.
- A long stall on `ent_ready`, which tests that the record holds and that taking is deferred.
- A reset request against a full set of pending events, which shows that they are discarded.

Seeded random traffic then mixes pulses, status writes and back-pressure. A level-mode instance and a falling-edge instance receive the same stimulus, so the two interrupt sensing modes can be told apart on identical input.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NKIND = 6;

  typedef enum logic [2:0] {
    K_RST = 3'd0,
    K_NMB = 3'd1,
    K_BRK = 3'd2,
    K_HWX = 3'd3,
    K_IRQ = 3'd4,
    K_USR = 3'd5
  } kind_e;

  function automatic logic [7:0] vec_of(kind_e k);
    case (k)
      K_RST:        vec_of = 8'h00;
      K_USR:        vec_of = 8'h08;
      K_IRQ:        vec_of = 8'h10;
      K_NMB, K_BRK: vec_of = 8'h18;
      K_HWX:        vec_of = 8'h20;
      default:      vec_of = 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] rf_of(kind_e k);
    case (k)
      K_USR:        rf_of = 5'd15;
      K_IRQ:        rf_of = 5'd14;
      K_NMB, K_BRK: rf_of = 5'd16;
      K_HWX:        rf_of = 5'd17;
      default:      rf_of = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/evt_hold.sv
module evt_hold #(
  parameter int W       = 1,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {W{RST_ONE}};
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter bit EDGE = 1'b0,
  parameter bit POS  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  output logic req
);
  generate
    if (EDGE) begin : g_edge
      logic prev, hold, hit;
      assign hit = POS ? (line & ~prev) : (~line & prev);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev <= POS;
          hold <= 1'b0;
        end else begin
          prev <= line;
          hold <= (hold & ~clr) | hit;
        end
      end
      assign req = hold;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = clk ^ rst_n ^ clr;
      assign req = line;
    end
  endgenerate
endmodule

// File: rtl/hw_cause_pick.sv
module hw_cause_pick #(
  parameter int N  = 5,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  sel,
  output logic [CW-1:0] id,
  output logic          any
);
  always_comb begin
    sel = '0;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel = '0;
        sel[i] = 1'b1;
        id = CW'(i + 1);
      end
    end
  end
  assign any = |pend;
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int NCAUSE   = 5,
  parameter bit IRQ_EDGE = 1'b0,
  parameter bit EDGE_POS = 1'b1,
  localparam int CW      = $clog2(NCAUSE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              nmbrk_req,
  input  logic              brk_req,
  input  logic              usr_req,
  input  logic [NCAUSE-1:0] hw_cause,
  input  logic              irq_line,
  input  logic [AW-1:0]     dec_pc,
  input  logic              msr_we,
  input  logic [2:0]        msr_wdata,
  input  logic              ent_ready,
  output logic              ent_valid,
  output logic [AW-1:0]     ent_vec,
  output logic [4:0]        ent_rf_idx,
  output logic [AW-1:0]     ent_ret_pc,
  output logic [CW-1:0]     ent_cause,
  output logic              ent_squash,
  output logic              st_ie,
  output logic              st_bip,
  output logic              st_ee
);
  localparam int NSRC = 4;
  localparam int KW   = $clog2(NKIND);

  logic [NSRC-1:0]   s_set, s_clr, s_pend;
  logic [NCAUSE-1:0] hw_pend, hw_sel, hw_clr;
  logic [CW-1:0]     hw_id;
  logic              hw_any;
  logic              irq_req, irq_clr;
  logic [NKIND-1:0]  req, grant;
  logic [KW-1:0]     kidx;
  logic              req_any, slot_free, take, take_rst;
  kind_e             kind;
  logic [2:0]        st_n;

  // single-bit pending sources: 0 reset, 1 non-maskable break, 2 break, 3 user
  assign s_set = {usr_req, brk_req, nmbrk_req, rst_req};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      evt_hold #(.W(1), .RST_ONE(g == 0)) u_hold (
        .clk(clk), .rst_n(rst_n), .set(s_set[g]), .clr(s_clr[g]), .q(s_pend[g])
      );
    end
  endgenerate

  evt_hold #(.W(NCAUSE), .RST_ONE(1'b0)) u_hw_hold (
    .clk(clk), .rst_n(rst_n), .set(hw_cause), .clr(hw_clr), .q(hw_pend)
  );

  hw_cause_pick #(.N(NCAUSE), .CW(CW)) u_pick (
    .pend(hw_pend), .sel(hw_sel), .id(hw_id), .any(hw_any)
  );

  irq_sense #(.EDGE(IRQ_EDGE), .POS(EDGE_POS)) u_irq (
    .clk(clk), .rst_n(rst_n), .line(irq_line), .clr(irq_clr), .req(irq_req)
  );

  // eligibility under the status flags
  always_comb begin
    req        = '0;
    req[K_RST] = s_pend[0];
    req[K_NMB] = s_pend[1];
    req[K_BRK] = s_pend[2] & ~st_bip;
    req[K_HWX] = hw_any & st_ee & ~st_bip;
    req[K_IRQ] = irq_req & st_ie & ~st_bip;
    req[K_USR] = s_pend[3];
  end

  exc_prio_arb #(.N(NKIND), .IW(KW)) u_arb (
    .req(req), .grant(grant), .idx(kidx), .any(req_any)
  );

  assign kind      = kind_e'(kidx);
  assign slot_free = ~ent_valid | ent_ready;
  assign take      = slot_free & req_any;
  assign take_rst  = take & grant[K_RST];

  assign s_clr[0] = take_rst;
  assign s_clr[1] = take_rst | (take & grant[K_NMB]);
  assign s_clr[2] = take_rst | (take & grant[K_BRK]);
  assign s_clr[3] = take_rst | (take & grant[K_USR]);
  assign hw_clr   = take_rst ? '1 : ((take & grant[K_HWX]) ? hw_sel : '0);
  assign irq_clr  = take_rst | (take & grant[K_IRQ]);

  // status flags: software write first, taken event on top
  always_comb begin
    st_n = msr_we ? msr_wdata : {st_ee, st_bip, st_ie};
    if (take) begin
      case (kind)
        K_RST:        st_n    = 3'b000;
        K_NMB, K_BRK: st_n[1] = 1'b1;
        K_HWX:        st_n[2] = 1'b0;
        K_IRQ:        st_n[0] = 1'b0;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {st_ee, st_bip, st_ie} <= 3'b000;
    else        {st_ee, st_bip, st_ie} <= st_n;
  end

  // entry record stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_vec    <= '0;
      ent_rf_idx <= '0;
      ent_ret_pc <= '0;
      ent_cause  <= '0;
      ent_squash <= 1'b0;
    end else if (take) begin
      ent_valid  <= 1'b1;
      ent_vec    <= AW'(vec_of(kind));
      ent_rf_idx <= rf_of(kind);
      ent_ret_pc <= (kind == K_RST) ? '0 : dec_pc;
      ent_cause  <= (kind == K_HWX) ? hw_id : '0;
      ent_squash <= (kind == K_RST) || (kind == K_HWX);
    end else if (ent_ready) begin
      ent_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take,
  input logic [5:0]    grant,
  input logic          ent_valid,
  input logic          ent_ready,
  input logic [AW-1:0] ent_vec,
  input logic [AW-1:0] ent_ret_pc,
  input logic [4:0]    ent_rf_idx,
  input logic          ent_squash,
  input logic          st_ie,
  input logic          st_bip,
  input logic          st_ee
);
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_vec) && $stable(ent_ret_pc) && $stable(ent_rf_idx));

  a_r8_take_slot: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!ent_valid || ent_ready));

  a_r8_take_shows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ent_valid);

  a_r4_irq_elig: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[4] |-> st_ie && !st_bip);

  a_r4_irq_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[4] |=> !st_ie);

  a_r5_brk_elig: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[2] |-> !st_bip);

  a_r5_bip_set: assert property (@(posedge clk) disable iff (!rst_n)
    take && (grant[1] || grant[2]) |=> st_bip);

  a_r6_hw_elig: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[3] |-> st_ee && !st_bip);

  a_r7_squash_kind: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_squash == (ent_vec == AW'(0) || ent_vec == AW'(32'h20)));

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take && grant[0] |=> !st_ie && !st_bip && !st_ee);
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .grant(grant),
  .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_vec(ent_vec),
  .ent_ret_pc(ent_ret_pc), .ent_rf_idx(ent_rf_idx), .ent_squash(ent_squash),
  .st_ie(st_ie), .st_bip(st_bip), .st_ee(st_ee)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  typedef struct {
    bit rst_req, nmb, brk, usr, irq, we, ready;
    bit [4:0] hw;
    bit [2:0] wd;
    bit [31:0] pc;
  } stim_t;

  typedef struct {
    bit prst, pnmb, pbrk, pusr, irqp, prev, ie, bip, ee, ov, sq;
    bit [4:0] phw;
    bit [31:0] vec, pc;
    bit [4:0] idx;
    bit [2:0] cause;
  } mdl_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  stim_t st;
  mdl_t  ma, mb;
  int    checks = 0, fails = 0;
  bit    done = 1'b0;

  logic a_v, a_sq, a_ie, a_bip, a_ee, b_v, b_sq, b_ie, b_bip, b_ee;
  logic [31:0] a_vec, a_pc, b_vec, b_pc;
  logic [4:0]  a_idx, b_idx;
  logic [2:0]  a_cs, b_cs;

  exc_entry_seq #(.IRQ_EDGE(1'b0)) u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(st.rst_req), .nmbrk_req(st.nmb), .brk_req(st.brk),
    .usr_req(st.usr), .hw_cause(st.hw), .irq_line(st.irq), .dec_pc(st.pc), .msr_we(st.we),
    .msr_wdata(st.wd), .ent_ready(st.ready), .ent_valid(a_v), .ent_vec(a_vec),
    .ent_rf_idx(a_idx), .ent_ret_pc(a_pc), .ent_cause(a_cs), .ent_squash(a_sq),
    .st_ie(a_ie), .st_bip(a_bip), .st_ee(a_ee));

  exc_entry_seq #(.IRQ_EDGE(1'b1), .EDGE_POS(1'b0)) u_exc_entry_seq_edge (
    .clk(clk), .rst_n(rst_n), .rst_req(st.rst_req), .nmbrk_req(st.nmb), .brk_req(st.brk),
    .usr_req(st.usr), .hw_cause(st.hw), .irq_line(st.irq), .dec_pc(st.pc), .msr_we(st.we),
    .msr_wdata(st.wd), .ent_ready(st.ready), .ent_valid(b_v), .ent_vec(b_vec),
    .ent_rf_idx(b_idx), .ent_ret_pc(b_pc), .ent_cause(b_cs), .ent_squash(b_sq),
    .st_ie(b_ie), .st_bip(b_bip), .st_ee(b_ee));

  function automatic mdl_t mreset(bit pos);
    mdl_t m = '{default: 0};
    m.prst = 1'b1;
    m.prev = pos;
    return m;
  endfunction

  // expected next state from the requirements
  function automatic mdl_t step(mdl_t s, stim_t in, bit edge_m, bit pos);
    mdl_t n = s;
    bit [5:0] rq;
    int k = -1, hb = 0;
    bit take, ca, ev;
    bit [4:0] hclr;
    bit [2:0] f;
    rq[0] = s.prst;
    rq[1] = s.pnmb;
    rq[2] = s.pbrk && !s.bip;
    rq[3] = (|s.phw) && s.ee && !s.bip;
    rq[4] = (edge_m ? s.irqp : in.irq) && s.ie && !s.bip;
    rq[5] = s.pusr;
    for (int i = 5; i >= 0; i--) if (rq[i]) k = i;
    for (int i = 4; i >= 0; i--) if (s.phw[i]) hb = i;
    take = (k >= 0) && (!s.ov || in.ready);
    ca = take && (k == 0);
    n.prst = (s.prst && !ca) || in.rst_req;
    n.pnmb = (s.pnmb && !(ca || (take && k == 1))) || in.nmb;
    n.pbrk = (s.pbrk && !(ca || (take && k == 2))) || in.brk;
    n.pusr = (s.pusr && !(ca || (take && k == 5))) || in.usr;
    hclr = ca ? 5'h1f : ((take && k == 3) ? (5'b1 << hb) : 5'h0);
    n.phw = (s.phw & ~hclr) | in.hw;
    ev = pos ? (!s.prev && in.irq) : (s.prev && !in.irq);
    n.prev = in.irq;
    n.irqp = (s.irqp && !(ca || (take && k == 4))) || ev;
    f = in.we ? in.wd : {s.ee, s.bip, s.ie};
    if (take) begin
      case (k)
        0: f = 3'b000;
        1, 2: f[1] = 1'b1;
        3: f[2] = 1'b0;
        4: f[0] = 1'b0;
        default: ;
      endcase
    end
    {n.ee, n.bip, n.ie} = f;
    if (take) begin
      n.ov = 1'b1;
      case (k)
        0: begin n.vec = 32'h00; n.idx = 5'd0;  end
        1, 2: begin n.vec = 32'h18; n.idx = 5'd16; end
        3: begin n.vec = 32'h20; n.idx = 5'd17; end
        4: begin n.vec = 32'h10; n.idx = 5'd14; end
        default: begin n.vec = 32'h08; n.idx = 5'd15; end
      endcase
      n.pc    = (k == 0) ? 32'h0 : in.pc;
      n.cause = (k == 3) ? 3'(hb + 1) : 3'd0;
      n.sq    = (k == 0) || (k == 3);
    end else if (in.ready) begin
      n.ov = 1'b0;
    end
    return n;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string tag);
    cmp({tag, " R8 valid"}, a_v, ma.ov);
    cmp({tag, " R4 ie"}, a_ie, ma.ie);
    cmp({tag, " R5 bip"}, a_bip, ma.bip);
    cmp({tag, " R6 ee"}, a_ee, ma.ee);
    if (ma.ov) begin
      cmp({tag, " R2 vec"}, a_vec, ma.vec);
      cmp({tag, " R2 idx"}, a_idx, ma.idx);
      cmp({tag, " R2 pc"}, a_pc, ma.pc);
      cmp({tag, " R6 cause"}, a_cs, ma.cause);
      cmp({tag, " R7 squash"}, a_sq, ma.sq);
    end
    cmp({tag, " R10 edge valid"}, b_v, mb.ov);
    cmp({tag, " R10 edge ie"}, b_ie, mb.ie);
    cmp({tag, " R10 edge bip"}, b_bip, mb.bip);
    if (mb.ov) begin
      cmp({tag, " R10 edge vec"}, b_vec, mb.vec);
      cmp({tag, " R10 edge cause"}, b_cs, mb.cause);
    end
  endtask

  // drive after falling edge, advance both models on the rising edge, compare shortly after
  task automatic tick(string tag);
    @(posedge clk);
    ma = step(ma, st, 1'b0, 1'b1);
    mb = step(mb, st, 1'b1, 1'b0);
    #2;
    cmp_all(tag);
    @(negedge clk);
    st.rst_req = 0; st.nmb = 0; st.brk = 0; st.usr = 0; st.hw = 0; st.we = 0;
    st.pc = st.pc + 32'd4;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    st = '{default: 0};
    st.ready = 1'b1;
    st.pc = 32'h1000;
    ma = mreset(1'b1);
    mb = mreset(1'b0);
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp("R1 valid in reset", a_v, 1'b0);
    cmp("R1 status in reset", {a_ee, a_bip, a_ie}, 3'b000);
    rst_n = 1'b1;
    tick("R1");
    cmp("R1 first vector", a_vec, 32'h0);
    cmp("R1 first squash", a_sq, 1'b1);
    idle("R1", 2);

    // R4: level interrupt masked by IE=0, taken after software sets IE
    st.irq = 1'b1;
    idle("R4 masked", 3);
    st.we = 1'b1; st.wd = 3'b001;
    idle("R4 taken", 4);
    st.irq = 1'b0;
    idle("R10 falling", 2);

    // R5: break sets BIP, repeat break blocked, non-maskable break still taken
    st.brk = 1'b1;
    idle("R5 brk", 3);
    st.brk = 1'b1;
    idle("R5 blocked", 3);
    st.nmb = 1'b1;
    idle("R5 nmb", 3);

    // R9: software clears BIP, enables EE, taking the stale break in the same cycle window
    st.we = 1'b1; st.wd = 3'b100;
    idle("R9 write", 3);

    // R6: two causes at once, lowest ID first, second waits for EE
    st.hw = 5'b01010;
    idle("R6 first", 3);
    st.we = 1'b1; st.wd = 3'b101;
    idle("R6 second", 3);

    // R3: several kinds in one cycle
    st.we = 1'b1; st.wd = 3'b101;
    tick("R3 setup");
    st.nmb = 1; st.brk = 1; st.usr = 1; st.hw = 5'b10000; st.irq = 1;
    idle("R3 order", 4);
    st.we = 1'b1; st.wd = 3'b101;
    idle("R3 release", 5);
    st.irq = 0;

    // R8: long stall with requests pending
    st.ready = 1'b0;
    st.usr = 1'b1;
    idle("R8 stall", 2);
    st.nmb = 1'b1;
    idle("R8 stall", 5);
    st.ready = 1'b1;
    idle("R8 drain", 4);

    // R11: reset request discards pending work
    st.ready = 1'b0;
    st.usr = 1; st.brk = 1; st.hw = 5'b00100;
    tick("R11 load");
    st.rst_req = 1'b1;
    idle("R11 load", 2);
    st.ready = 1'b1;
    idle("R11 reset", 5);

    // seeded random traffic
    for (int c = 0; c < 4000; c++) begin
      st.rst_req = ($urandom % 400) == 0;
      st.nmb     = ($urandom % 60) == 0;
      st.brk     = ($urandom % 25) == 0;
      st.usr     = ($urandom % 20) == 0;
      st.hw      = (($urandom % 15) == 0) ? 5'(($urandom % 32)) : 5'd0;
      if (($urandom % 8) == 0) st.irq = ~st.irq;
      st.we      = ($urandom % 10) == 0;
      st.wd      = 3'($urandom % 8);
      st.ready   = ($urandom % 4) != 0;
      st.pc      = $urandom;
      tick("RND R2 R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule